// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI bus master that a processor drives through a small word-addressed register port with read and write strobes. Software configures the clock polarity, clock phase, frame size (8 or 16 bits), a burst length given as a frame count minus one, and an even clock divider. It picks one slave through a one-hot select register and fills a transmit FIFO. Setting the run bit then starts a full-duplex burst. Each frame takes one transmit entry and returns one receive entry. Bits move most significant first, and the select line stays low for the whole burst.

Configuration is frozen while the run bit is set. Clearing the run bit stops the engine, flushes both FIFOs and rewinds the frame counter. A status word reports activity and the fill state of both FIFOs. Software pushes transmit data while the transmit FIFO is not full and pops receive data while the receive FIFO is not empty. If the transmit FIFO runs dry in the middle of a burst, the serial clock parks at its idle level until more data arrives.

Top module: `spim_ctrl`

## Requirements
- R1: Register word addresses are: 0 config (bit0 clock idle level, bit1 sample-on-second-edge, bit2 16-bit frames), 1 frame count minus one (16 bits), 2 run bit (bit0), 3 slave select, 4 divider (low 16 bits), 5 status, 6 transmit data (write), 7 receive data (read, pops). Read data appears on `rdata` in the cycle after `rd_en`. After reset every register is 0 and status reads 0x0C.
- R2: A burst moves exactly frame-count+1 frames and then stops. Each frame consumes one transmit entry and pushes one receive entry, so after a burst that consumed every pushed word the status transmit-empty bit (bit3) reads 1.
- R3: Writes to config, frame count and divider are ignored while the run bit is 1.
- R4: Each FIFO holds 32 entries. A push into a full transmit FIFO is dropped. Status bit1 is transmit-full and bit4 is receive-full.
- R5: Each half period of the serial clock lasts floor(divider/2) module clocks. The divider LSB is ignored, and values below 2 act as 2.
- R6: The clock idles at the polarity bit. With the phase bit 0, data is sampled on the first edge of each bit. With the phase bit 1, it is sampled on the second edge. All four modes move data correctly in both directions.
- R7: In 8-bit mode only the low byte of a transmit word is sent, and receive words read with the upper byte zero. In 16-bit mode all 16 bits move, most significant bit first.
- R8: `ss_n` is the bitwise inverse of the select register. A written value with more than one bit set is ignored, and 0 releases every select.
- R9: The first serial clock edge of a burst comes no sooner than one full serial clock period (the even divider value, in module clocks) after the run bit is written.
- R10: An empty transmit FIFO mid-burst holds the clock at idle with the engine busy. The burst resumes when data is pushed.
- R11: Status bit0 (busy) is 1 from the run-bit write until the last frame completes with the clock back at idle, and 0 afterwards.
- R12: Clearing the run bit empties both FIFOs (status bits 2 and 3 read 1) and rewinds the frame counter, so stale data never reaches a later burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ss_n | output | 4 | Active-low slave selects |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |

## Verification
Assertions check on every cycle that configuration never moves while the run bit is set and that the select register never holds more than one bit. They also check that the serial clock changes only on a divider tick and sits at its idle level outside the shift state, and that no frame is pushed past the programmed count. Only the bench's scenarios can show the end-to-end behaviour. That covers correct data in both directions for all four modes and both frame sizes, the exact half-period length including odd and sub-minimum dividers, and the delay before the first edge. It also covers the stall on an empty transmit FIFO, the dropped 33rd push, and the flush that keeps stale words out of the next burst.

// File: rtl/spim_pkg.sv
package spim_pkg;

   localparam int A_CFG = 0;
   localparam int A_CNT = 1;
   localparam int A_RUN = 2;
   localparam int A_SEL = 3;
   localparam int A_DIV = 4;
   localparam int A_STS = 5;
   localparam int A_TXD = 6;
   localparam int A_RXD = 7;

   localparam int FRAME_W = 16;

   typedef struct packed {
      logic wide;
      logic cpha;
      logic cpol;
   } spim_cfg_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_LOAD,
      ST_SHIFT,
      ST_FIN
   } spim_state_e;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             full,
   output logic             empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("spim_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt;
   logic             do_push, do_pop;

   assign full    = (cnt == CNT_W'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else if (clear) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         if (do_push && !do_pop) cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clear) mem[wr_ptr] <= push_data;
   end

   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));

endmodule

// File: rtl/spim_tick.sv
module spim_tick #(
   parameter int W = 15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] half,
   output logic         tick
);
   generate
      if (W < 1) begin : g_bad_w
         $error("spim_tick: W must be positive");
      end
   endgenerate

   logic [W-1:0] cnt;

   assign tick = run && (cnt == half - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (!run)  cnt <= '0;
      else if (tick)  cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/spim_engine.sv
module spim_engine
   import spim_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int DIV_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  spim_cfg_t          cfg,
   input  logic [CNT_W-1:0]   frames_m1,
   input  logic [DIV_W-1:0]   div,
   input  logic               tx_empty,
   input  logic [FRAME_W-1:0] tx_data,
   input  logic               rx_full,
   input  logic               miso,
   output logic               tx_pop,
   output logic               rx_push,
   output logic [FRAME_W-1:0] rx_data,
   output logic               sclk,
   output logic               mosi,
   output logic               busy
);
   localparam int HALF_W = DIV_W - 1;
   localparam int BIT_W  = $clog2(FRAME_W);

   generate
      if (DIV_W < 2) begin : g_bad_div
         $error("spim_engine: DIV_W must be at least 2");
      end
   endgenerate

   spim_state_e        state;
   logic               phase, lead_ph, sclk_act;
   logic [BIT_W-1:0]   bit_cnt;
   logic [CNT_W-1:0]   fcnt;
   logic [FRAME_W-1:0] tx_sh, rx_sh, rx_next, rx_word;
   logic [HALF_W-1:0]  half;
   logic               tick, tick_run, lead_tick, trail_tick, sample, last_bit;

   assign half     = (div[DIV_W-1:1] == '0) ? HALF_W'(1) : div[DIV_W-1:1];
   assign tick_run = (state == ST_LEAD) || (state == ST_SHIFT);

   spim_tick #(.W(HALF_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (tick_run),
      .half (half),
      .tick (tick)
   );

   assign last_bit   = (bit_cnt == (cfg.wide ? BIT_W'(FRAME_W - 1) : BIT_W'(FRAME_W / 2 - 1)));
   assign lead_tick  = (state == ST_SHIFT) && tick && !phase;
   assign trail_tick = (state == ST_SHIFT) && tick && phase;
   assign sample     = cfg.cpha ? trail_tick : lead_tick;
   assign rx_next    = {rx_sh[FRAME_W-2:0], miso};
   assign rx_word    = sample ? rx_next : rx_sh;
   assign rx_data    = cfg.wide ? rx_word : {{(FRAME_W/2){1'b0}}, rx_word[FRAME_W/2-1:0]};
   assign rx_push    = trail_tick && last_bit;
   assign tx_pop     = (state == ST_LOAD) && !tx_empty && !rx_full;
   assign sclk       = sclk_act ^ cfg.cpol;
   assign mosi       = tx_sh[FRAME_W-1];
   assign busy       = en && (state != ST_FIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         phase    <= 1'b0;
         lead_ph  <= 1'b0;
         sclk_act <= 1'b0;
         bit_cnt  <= '0;
         fcnt     <= '0;
         tx_sh    <= '0;
         rx_sh    <= '0;
      end else if (!en) begin
         state    <= ST_IDLE;
         phase    <= 1'b0;
         lead_ph  <= 1'b0;
         sclk_act <= 1'b0;
         bit_cnt  <= '0;
         fcnt     <= '0;
         tx_sh    <= '0;
         rx_sh    <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               state   <= ST_LEAD;
               lead_ph <= 1'b0;
            end
            ST_LEAD: begin
               if (tick) begin
                  lead_ph <= 1'b1;
                  if (lead_ph) state <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               if (tx_pop) begin
                  tx_sh   <= cfg.wide ? tx_data
                                      : {tx_data[FRAME_W/2-1:0], {(FRAME_W/2){1'b0}}};
                  bit_cnt <= '0;
                  phase   <= 1'b0;
                  state   <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!phase) begin
                     sclk_act <= 1'b1;
                     phase    <= 1'b1;
                     if (cfg.cpha && (bit_cnt != '0)) tx_sh <= tx_sh << 1;
                  end else begin
                     sclk_act <= 1'b0;
                     phase    <= 1'b0;
                     if (last_bit) begin
                        if (fcnt == frames_m1) begin
                           state <= ST_FIN;
                        end else begin
                           fcnt  <= fcnt + 1'b1;
                           state <= ST_LOAD;
                        end
                     end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (!cfg.cpha) tx_sh <= tx_sh << 1;
                     end
                  end
                  if (sample) rx_sh <= rx_next;
               end
            end
            default: ;
         endcase
      end
   end

   // R6: clock parked at its idle level outside the shift state
   a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_SHIFT) |-> (sclk == cfg.cpol));

   // R5: while running, the serial clock only moves on a divider tick
   a_r5_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && (sclk != $past(sclk))) |-> $past(tick));

   // R2: no frame is returned beyond the programmed count
   a_r2_frame_limit: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> (fcnt <= frames_m1));

   // R11: a finished burst leaves the clock at rest
   a_r11_fin_rest: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FIN) |-> !sclk_act);

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
   import spim_pkg::*;
#(
   parameter int FIFO_DEPTH = 32,
   parameter int NUM_SS     = 4,
   parameter int ADDR_W     = 3,
   parameter int BUS_W      = 32,
   parameter int CNT_W      = 16,
   parameter int DIV_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   output logic [NUM_SS-1:0] ss_n,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso
);
   localparam int STS_W = 5;

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("spim_ctrl: ADDR_W must be at least 3");
      end
      if (NUM_SS < 1 || NUM_SS >= BUS_W) begin : g_bad_ss
         $error("spim_ctrl: NUM_SS out of range");
      end
      if (CNT_W > BUS_W || DIV_W > BUS_W || FRAME_W > BUS_W) begin : g_bad_w
         $error("spim_ctrl: field wider than bus");
      end
   endgenerate

   spim_cfg_t          cfg_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [DIV_W-1:0]   div_q;
   logic [NUM_SS-1:0]  sel_q;
   logic               en_q;

   logic wr_cfg, wr_cnt, wr_run, wr_sel, wr_div, wr_txd, rd_rxd;
   logic flush, sel_ok;

   logic               tx_full, tx_empty, rx_full, rx_empty;
   logic [FRAME_W-1:0] tx_head, rx_head, rx_word;
   logic               tx_pop, rx_push, busy;
   logic [BUS_W-1:0]   rd_mux;

   assign wr_cfg = wr_en && (addr == ADDR_W'(A_CFG));
   assign wr_cnt = wr_en && (addr == ADDR_W'(A_CNT));
   assign wr_run = wr_en && (addr == ADDR_W'(A_RUN));
   assign wr_sel = wr_en && (addr == ADDR_W'(A_SEL));
   assign wr_div = wr_en && (addr == ADDR_W'(A_DIV));
   assign wr_txd = wr_en && (addr == ADDR_W'(A_TXD));
   assign rd_rxd = rd_en && (addr == ADDR_W'(A_RXD));

   assign sel_ok = $onehot0(wdata[NUM_SS-1:0]) && (wdata[BUS_W-1:NUM_SS] == '0);
   assign flush  = wr_run && en_q && !wdata[0];
   assign ss_n   = ~sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         cnt_q <= '0;
         div_q <= '0;
         sel_q <= '0;
         en_q  <= 1'b0;
      end else begin
         if (wr_cfg && !en_q) cfg_q <= spim_cfg_t'(wdata[2:0]);
         if (wr_cnt && !en_q) cnt_q <= wdata[CNT_W-1:0];
         if (wr_div && !en_q) div_q <= wdata[DIV_W-1:0];
         if (wr_sel && sel_ok) sel_q <= wdata[NUM_SS-1:0];
         if (wr_run) en_q <= wdata[0];
      end
   end

   spim_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (flush),
      .push     (wr_txd),
      .push_data(wdata[FRAME_W-1:0]),
      .pop      (tx_pop),
      .head     (tx_head),
      .full     (tx_full),
      .empty    (tx_empty)
   );

   spim_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (flush),
      .push     (rx_push),
      .push_data(rx_word),
      .pop      (rd_rxd),
      .head     (rx_head),
      .full     (rx_full),
      .empty    (rx_empty)
   );

   spim_engine #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_q),
      .cfg      (cfg_q),
      .frames_m1(cnt_q),
      .div      (div_q),
      .tx_empty (tx_empty),
      .tx_data  (tx_head),
      .rx_full  (rx_full),
      .miso     (miso),
      .tx_pop   (tx_pop),
      .rx_push  (rx_push),
      .rx_data  (rx_word),
      .sclk     (sclk),
      .mosi     (mosi),
      .busy     (busy)
   );

   always_comb begin
      rd_mux = '0;
      case (addr)
         ADDR_W'(A_CFG): rd_mux[2:0]        = cfg_q;
         ADDR_W'(A_CNT): rd_mux[CNT_W-1:0]  = cnt_q;
         ADDR_W'(A_RUN): rd_mux[0]          = en_q;
         ADDR_W'(A_SEL): rd_mux[NUM_SS-1:0] = sel_q;
         ADDR_W'(A_DIV): rd_mux[DIV_W-1:0]  = div_q;
         ADDR_W'(A_STS): rd_mux[STS_W-1:0]  = {rx_full, tx_empty, rx_empty, tx_full, busy};
         ADDR_W'(A_RXD): rd_mux[FRAME_W-1:0] = rx_empty ? '0 : rx_head;
         default:        rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
   end

   // R3: settings hold still for as long as the run bit stays set
   a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && $past(en_q)) |-> ($stable(cfg_q) && $stable(cnt_q) && $stable(div_q)));

   // R8: never more than one select driven
   a_r8_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ss_n));

endmodule

// File: tb/spim_ctrl_tb_top.sv
module spim_ctrl_tb_top;
   localparam int A_CFG = 0, A_CNT = 1, A_RUN = 2, A_SEL = 3;
   localparam int A_DIV = 4, A_STS = 5, A_TXD = 6, A_RXD = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  ss_n;
   logic        sclk, mosi, miso;

   always #5 clk = ~clk;

   spim_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .ss_n(ss_n), .sclk(sclk), .mosi(mosi), .miso(miso)
   );

   int n_chk = 0, n_bad = 0, cyc = 0;
   always @(posedge clk) cyc = cyc + 1;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a[2:0]; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a[2:0];
      @(negedge clk); rd_en = 1'b0; d = rdata;
   endtask

   // ---------------- slave model ----------------
   bit          slv_on = 1'b0, cpol_b = 1'b0, cpha_b = 1'b0, wide_b = 1'b0;
   int          half_b = 1, lead_n = 0, trail_n = 0, s_frames = 0;
   int          gap_bad = 0, first_edge = -1, last_edge = 0;
   logic [15:0] s_tx [64];
   logic [15:0] s_rx [64];
   logic [15:0] s_cap = '0;
   logic [15:0] sent [64];
   int          n_sent = 0;

   always @(sclk) begin
      if (slv_on) begin
         if (lead_n != 0 || trail_n != 0) begin
            if (cyc - last_edge != half_b) gap_bad++;
         end else if (s_frames == 0 && first_edge < 0) begin
            first_edge = cyc;
         end
         last_edge = cyc;
         if (sclk != cpol_b) begin
            if (!cpha_b) s_cap = {s_cap[14:0], mosi};
            lead_n++;
         end else begin
            if (cpha_b) s_cap = {s_cap[14:0], mosi};
            trail_n++;
            if (trail_n == (wide_b ? 16 : 8)) begin
               s_rx[s_frames & 63] = wide_b ? s_cap : {8'h00, s_cap[7:0]};
               s_frames++;
               lead_n  = 0;
               trail_n = 0;
            end
         end
      end
   end

   always @* begin
      int idx;
      idx  = cpha_b ? ((lead_n > 0) ? lead_n - 1 : 0) : trail_n;
      miso = s_tx[s_frames & 63][(wide_b ? 15 : 7) - idx];
   end

   task automatic slv_setup(input bit cp, input bit ph, input bit wd, input int dv);
      logic [31:0] r;
      wr(A_CFG, {29'h0, wd, ph, cp});
      wr(A_DIV, dv);
      cpol_b = cp; cpha_b = ph; wide_b = wd;
      half_b = (dv & 32'hFFFE) >> 1;
      if (half_b == 0) half_b = 1;
      lead_n = 0; trail_n = 0; s_frames = 0; gap_bad = 0; first_edge = -1; n_sent = 0;
      for (int i = 0; i < 64; i++) begin
         r = $urandom;
         s_tx[i] = r[15:0];
         s_rx[i] = '0;
      end
   endtask

   task automatic push(input logic [15:0] w);
      sent[n_sent & 63] = wide_b ? w : {8'h00, w[7:0]};
      n_sent++;
      wr(A_TXD, {16'h0, w});
   endtask

   task automatic wait_idle(input string tag);
      logic [31:0] d;
      int polls;
      polls = 0;
      d = 32'h1;
      while (d[0] && polls < 20000) begin
         rd(A_STS, d);
         polls++;
      end
      chk(d[0] == 1'b0, tag, d, 32'h0);
   endtask

   task automatic check_data(input int nf);
      logic [31:0] d;
      logic [15:0] exp;
      chk(s_frames == nf, "R2 frames seen by slave", s_frames, nf);
      for (int i = 0; i < nf; i++) begin
         chk(s_rx[i] == sent[i], "R6 R7 mosi frame data", s_rx[i], sent[i]);
         rd(A_RXD, d);
         exp = wide_b ? s_tx[i] : {8'h00, s_tx[i][7:0]};
         chk(d == {16'h0, exp}, "R6 R7 miso frame data", d, {16'h0, exp});
      end
      chk(gap_bad == 0, "R5 half-period length", gap_bad, 0);
      chk(sclk == cpol_b, "R6 R11 idle level after burst", sclk, cpol_b);
   endtask

   task automatic burst(input bit cp, input bit ph, input bit wd, input int dv, input int nf, input int npush);
      logic [31:0] d, r;
      int en_c, dv_even;
      slv_setup(cp, ph, wd, dv);
      wr(A_CNT, nf - 1);
      for (int i = 0; i < npush; i++) begin
         r = $urandom;
         push(r[15:0]);
      end
      if (npush >= 32) begin
         rd(A_STS, d);
         chk(d[1] == 1'b1, "R4 transmit full flag", d, 32'h2);
      end
      slv_on = 1'b1;
      wr(A_RUN, 1);
      en_c = cyc;
      rd(A_STS, d);
      chk(d[0] == 1'b1, "R11 busy after run write", d, 32'h1);
      wait_idle("R11 busy falls at end");
      rd(A_STS, d);
      chk(d[3] == 1'b1, "R2 R4 transmit empty after burst", d, 32'h8);
      if (nf == 32) chk(d[4] == 1'b1, "R4 receive full at 32", d, 32'h10);
      dv_even = dv & 32'hFFFE;
      if (dv_even < 2) dv_even = 2;
      chk(first_edge - en_c >= dv_even, "R9 lead delay", first_edge - en_c, dv_even);
      check_data(nf);
      slv_on = 1'b0;
      wr(A_RUN, 0);
   endtask

   initial begin
      logic [31:0] d, r;
      void'($urandom(32'h5EED_1234));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_STS, d); chk(d == 32'h0C, "R1 reset status", d, 32'h0C);
      rd(A_CFG, d); chk(d == 32'h0, "R1 reset config", d, 32'h0);
      chk(ss_n == 4'hF, "R8 reset selects", ss_n, 4'hF);
      chk(sclk == 1'b0, "R11 reset clock level", sclk, 0);

      // R8 select handling
      wr(A_SEL, 32'h4); chk(ss_n == 4'b1011, "R8 select one", ss_n, 4'b1011);
      wr(A_SEL, 32'h3); chk(ss_n == 4'b1011, "R8 multi-bit ignored", ss_n, 4'b1011);
      rd(A_SEL, d); chk(d == 32'h4, "R1 select readback", d, 32'h4);
      wr(A_SEL, 32'h0); chk(ss_n == 4'hF, "R8 release all", ss_n, 4'hF);
      wr(A_SEL, 32'h1);

      // directed bursts: each mode, odd and tiny dividers
      burst(1'b0, 1'b0, 1'b0, 2, 4, 4);
      burst(1'b1, 1'b1, 1'b1, 7, 3, 3);
      burst(1'b0, 1'b1, 1'b0, 1, 2, 2);
      burst(1'b1, 1'b0, 1'b1, 4, 5, 5);

      // R4 depth: 33 pushes, 32 frames, the extra push is dropped
      burst(1'b0, 1'b0, 1'b0, 2, 32, 33);

      // random bursts
      for (int k = 0; k < 6; k++) begin
         r = $urandom;
         burst(r[0], r[1], r[2], 2 + int'(r[7:4] % 10), 1 + int'(r[15:8] % 12), 0 + 1 + int'(r[15:8] % 12));
      end

      // R10 starvation and R3 frozen configuration
      slv_setup(1'b0, 1'b0, 1'b0, 4);
      wr(A_CNT, 4);
      r = $urandom; push(r[15:0]);
      r = $urandom; push(r[15:0]);
      slv_on = 1'b1;
      wr(A_RUN, 1);
      repeat (300) @(negedge clk);
      rd(A_STS, d); chk(d[0] == 1'b1, "R10 busy while starved", d, 32'h1);
      chk(s_frames == 2, "R10 frames before stall", s_frames, 2);
      chk(sclk == 1'b0, "R10 clock idle while starved", sclk, 0);
      wr(A_CFG, 32'h7); rd(A_CFG, d); chk(d == 32'h0, "R3 config write ignored", d, 32'h0);
      wr(A_DIV, 32'hA); rd(A_DIV, d); chk(d == 32'h4, "R3 divider write ignored", d, 32'h4);
      wr(A_CNT, 32'h9); rd(A_CNT, d); chk(d == 32'h4, "R3 count write ignored", d, 32'h4);
      for (int i = 0; i < 3; i++) begin
         r = $urandom; push(r[15:0]);
      end
      wait_idle("R10 burst resumes and ends");
      check_data(5);
      slv_on = 1'b0;
      wr(A_RUN, 0);

      // R12 flush on run clear
      slv_setup(1'b0, 1'b0, 1'b0, 2);
      wr(A_CNT, 0);
      push(16'h0011); push(16'h0022); push(16'h0033);
      slv_on = 1'b1;
      wr(A_RUN, 1);
      wait_idle("R12 single frame ends");
      chk(s_frames == 1, "R2 R12 single frame", s_frames, 1);
      rd(A_STS, d); chk(d[3:2] == 2'b00, "R12 both queues hold data", d, 32'h0);
      wr(A_RUN, 0);
      rd(A_STS, d); chk(d[3:2] == 2'b11, "R12 queues flushed", d, 32'hC);
      lead_n = 0; trail_n = 0; s_frames = 0; n_sent = 0; first_edge = -1;
      push(16'h005A);
      wr(A_RUN, 1);
      wait_idle("R12 second burst ends");
      chk(s_frames == 1, "R12 counter rewound", s_frames, 1);
      chk(s_rx[0] == 16'h005A, "R12 no stale transmit word", s_rx[0], 16'h005A);
      rd(A_RXD, d);
      chk(d[15:0] == {8'h00, s_tx[0][7:0]}, "R12 no stale receive word", d, {24'h0, s_tx[0][7:0]});
      slv_on = 1'b0;
      wr(A_RUN, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule